// File: doc/BRIEF.md
# Memory Block Copy and Fill Engine

This block runs one operation over a contiguous memory region, element by element, in the manner of a repeated string instruction executed in hardware. Before a run, the caller places a source address, a destination address, an element size, an element count, a fill constant and an operation code on the configuration inputs. A one-cycle start pulse captures them and begins the run. The direction is held in a separate flag that two pulse inputs set and clear.

Each element is moved over a single synchronous memory port. A copy reads the element at the source address and then writes it at the destination address. A fill writes the constant at the destination address. After every element, both addresses move by the element size, upward or downward. A sticky done flag reports the end of the run.

Top module: `blkop_engine`

## Requirements
- R1: With op code 0 (copy), each element is read from the source region and written unchanged at the matching destination position. When the two regions overlap, the result equals a sequential element-by-element copy in which each element is fully read before it is written.
- R2: With op code 1 (fill), every destination element receives the low bytes of `cfg_fill`: 1, 2 or 4 bytes, according to the element size.
- R3: `cfg_size` selects the element width: 0 is a byte, 1 is 2 bytes, and 2 or 3 is 4 bytes.
- R4: The direction flag `dir_down` is 0 (forward, addresses increase) after reset. A `dir_down_set` pulse makes it 1 (addresses decrease). A `dir_up_set` pulse makes it 0 and wins when both pulses arrive in the same cycle. Each run uses the flag value present when the run starts.
- R5: A run performs exactly `cfg_count` element writes. The count is in elements, not bytes.
- R6: After each element, the source and destination addresses each move by the element size in bytes, added or subtracted according to the run direction. Addresses wrap modulo 2^AW.
- R7: A start with a count of zero performs no memory access. `done` is 1 and `busy` is 0 in the cycle after the start.
- R8: A copy spends one read cycle (`mem_re`=1) followed by one write cycle per element, so it is busy for 2×count cycles. A fill writes in every busy cycle, so it is busy for count cycles. Write data comes from the read data returned one cycle after the read.
- R9: A start while `busy` is 1 is ignored. The running transfer and its captured configuration are unchanged.
- R10: `done` is 0 while busy and is set when the last element is written. It stays 1 until the next accepted start clears it.
- R11: On a write, byte lane i of `mem_be` is set exactly when i−addr[LW−1:0] lies in 0..bytes−1, where bytes is the element size. The element's byte k appears on lane addr[LW−1:0]+k. Lanes past the top of the word are dropped. `mem_be` is 0 when no write occurs.
- R12: `mem_addr` carries the source address during read cycles and the destination address during write cycles. The data word at a byte address is the one whose address has the low LW bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures the configuration when idle |
| dir_down_set | input | 1 | Pulse that selects downward address stepping |
| dir_up_set | input | 1 | Pulse that selects upward address stepping |
| cfg_size | input | 2 | Element size code |
| cfg_op | input | 1 | 0 = copy, 1 = fill |
| cfg_src | input | AW | Source start byte address |
| cfg_dst | input | AW | Destination start byte address |
| cfg_count | input | CW | Number of elements |
| cfg_fill | input | 32 | Fill constant |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Sticky completion flag |
| dir_down | output | 1 | Current direction flag |
| mem_re | output | 1 | Read cycle |
| mem_we | output | 1 | Write cycle |
| mem_addr | output | AW | Byte address |
| mem_be | output | DW/8 | Byte lane write enables |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after the read |

## Verification
The bench builds the engine with AW=10 and CW=8, so a 1 KiB byte array can mirror the whole address space and be compared in full after every run. DW stays at 32, which puts all four lane offsets of the byte and 2-byte sizes within reach. Counts up to 40 elements reach both directions, overlapping regions and single-element runs without wrapping. The directed part adds a zero count, a start that lands mid-run and simultaneous direction pulses.

// File: rtl/blkop_pkg.sv
package blkop_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_WRD3 = 2'd3
   } esize_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } bstate_e;

   function automatic logic [2:0] esize_bytes(input logic [1:0] code);
      case (code)
         2'd0:    esize_bytes = 3'd1;
         2'd1:    esize_bytes = 3'd2;
         default: esize_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [3:0] esize_mask(input logic [1:0] code);
      case (code)
         2'd0:    esize_mask = 4'b0001;
         2'd1:    esize_mask = 4'b0011;
         default: esize_mask = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/blkop_addr_step.sv
module blkop_addr_step #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          step,
   input  logic          down,
   input  logic [2:0]    nbytes,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] incr;
   assign incr = AW'(nbytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_addr;
      end else if (step) begin
         addr <= down ? (addr - incr) : (addr + incr);
      end
   end

endmodule

// File: rtl/blkop_lane.sv
module blkop_lane #(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int LW = $clog2(NB)
) (
   input  logic [1:0]    size,
   input  logic          is_fill,
   input  logic [LW-1:0] src_lo,
   input  logic [LW-1:0] dst_lo,
   input  logic [DW-1:0] rd_data,
   input  logic [31:0]   fill,
   output logic [NB-1:0] be,
   output logic [DW-1:0] wdata
);

   logic [3:0]    emask;
   logic [DW-1:0] shifted;
   logic [31:0]   elem;

   assign emask   = blkop_pkg::esize_mask(size);
   assign shifted = rd_data >> {src_lo, 3'b000};
   assign elem    = is_fill ? fill : shifted[31:0];

   for (genvar j = 0; j < NB; j++) begin : g_lane
      logic [LW:0] rel;
      logic        in_rng;
      assign rel    = (LW + 1)'(j) - {1'b0, dst_lo};
      assign in_rng = !rel[LW] && (rel < (LW + 1)'(4));
      assign be[j]  = in_rng && emask[rel[1:0]];
      assign wdata[8*j +: 8] = elem[{rel[1:0], 3'b000} +: 8];
   end

endmodule

// File: rtl/blkop_ctrl.sv
module blkop_ctrl
   import blkop_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count,
   input  logic          is_fill,
   output bstate_e       state,
   output logic          run_fill,
   output logic          done,
   output logic          busy,
   output logic          load,
   output logic          step
);

   logic [CW-1:0] remain;

   assign busy = (state != ST_IDLE);
   assign load = start && !busy;
   assign step = (state == ST_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         remain   <= '0;
         run_fill <= 1'b0;
         done     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  run_fill <= is_fill;
                  if (count == '0) begin
                     done <= 1'b1;
                  end else begin
                     done   <= 1'b0;
                     remain <= count;
                     state  <= is_fill ? ST_WRITE : ST_READ;
                  end
               end
            end
            ST_READ: state <= ST_WRITE;
            ST_WRITE: begin
               remain <= remain - 1'b1;
               if (remain == CW'(1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= run_fill ? ST_WRITE : ST_READ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blkop_engine.sv
module blkop_engine
   import blkop_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int LW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          dir_down_set,
   input  logic          dir_up_set,
   input  logic [1:0]    cfg_size,
   input  logic          cfg_op,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic [CW-1:0] cfg_count,
   input  logic [31:0]   cfg_fill,
   output logic          busy,
   output logic          done,
   output logic          dir_down,
   output logic          mem_re,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [NB-1:0] mem_be,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);

   if (DW != 32 && DW != 64) begin : g_bad_dw
      $error("blkop_engine: DW must be 32 or 64");
   end
   if (AW < LW + 2) begin : g_bad_aw
      $error("blkop_engine: AW too small for the lane count");
   end
   if (CW < 1) begin : g_bad_cw
      $error("blkop_engine: CW must be at least 1");
   end

   bstate_e       state;
   logic          run_fill, load, step;
   logic          run_down;
   logic [1:0]    run_size;
   logic [31:0]   run_fill_val;
   logic [2:0]    nbytes;
   logic [AW-1:0] src_addr, dst_addr;
   logic [NB-1:0] lane_be;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_down <= 1'b0;
      end else if (dir_up_set) begin
         dir_down <= 1'b0;
      end else if (dir_down_set) begin
         dir_down <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_down     <= 1'b0;
         run_size     <= 2'd0;
         run_fill_val <= '0;
      end else if (load) begin
         run_down     <= dir_down;
         run_size     <= cfg_size;
         run_fill_val <= cfg_fill;
      end
   end

   assign nbytes = esize_bytes(run_size);

   blkop_ctrl #(.CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .count    (cfg_count),
      .is_fill  (cfg_op),
      .state    (state),
      .run_fill (run_fill),
      .done     (done),
      .busy     (busy),
      .load     (load),
      .step     (step)
   );

   blkop_addr_step #(.AW(AW)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_src),
      .step      (step),
      .down      (run_down),
      .nbytes    (nbytes),
      .addr      (src_addr)
   );

   blkop_addr_step #(.AW(AW)) u_dst (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_dst),
      .step      (step),
      .down      (run_down),
      .nbytes    (nbytes),
      .addr      (dst_addr)
   );

   blkop_lane #(.DW(DW)) u_lane (
      .size    (run_size),
      .is_fill (run_fill),
      .src_lo  (src_addr[LW-1:0]),
      .dst_lo  (dst_addr[LW-1:0]),
      .rd_data (mem_rdata),
      .fill    (run_fill_val),
      .be      (lane_be),
      .wdata   (mem_wdata)
   );

   assign mem_re   = (state == ST_READ);
   assign mem_we   = (state == ST_WRITE);
   assign mem_addr = mem_re ? src_addr : dst_addr;
   assign mem_be   = mem_we ? lane_be : '0;

endmodule

// File: rtl/blkop_engine_chk.sv
module blkop_engine_chk #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 32,
   localparam int NB = DW / 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          mem_re,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [NB-1:0] mem_be,
   input logic          run_fill,
   input logic          run_down,
   input logic [1:0]    run_size,
   input logic [CW-1:0] cfg_count
);

   logic [AW-1:0] stp;
   assign stp = AW'(blkop_pkg::esize_bytes(run_size));

   // R10
   done_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R7
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (cfg_count == '0) |=> done && !busy && !mem_we && !mem_re);

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && busy |=> $stable(run_size) && $stable(run_down) && $stable(run_fill));

   // R8
   copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && !run_fill |-> $past(mem_re));

   // R8
   fill_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && run_fill |-> mem_we && !mem_re);

   // R11
   be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> (mem_be == '0));

   // R11
   be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_be) >= 1) && ($countones(mem_be) <= int'(stp)));

   // R6
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && run_fill && $past(mem_we) |->
      mem_addr == (run_down ? $past(mem_addr) - stp : $past(mem_addr) + stp));

   // R6
   copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re && $past(busy) && $past(mem_re, 2) |->
      mem_addr == (run_down ? $past(mem_addr, 2) - stp : $past(mem_addr, 2) + stp));

endmodule

bind blkop_engine blkop_engine_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .mem_re    (mem_re),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .run_fill  (run_fill),
   .run_down  (run_down),
   .run_size  (run_size),
   .cfg_count (cfg_count)
);

// File: tb/blkop_engine_bench.sv
module blkop_engine_bench;

   localparam int AW = 10;
   localparam int CW = 8;
   localparam int DW = 32;
   localparam int MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          dir_down_set = 1'b0;
   logic          dir_up_set = 1'b0;
   logic [1:0]    cfg_size = 2'd0;
   logic          cfg_op = 1'b0;
   logic [AW-1:0] cfg_src = '0;
   logic [AW-1:0] cfg_dst = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [31:0]   cfg_fill = '0;
   logic          busy, done, dir_down, mem_re, mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int wcount = 0;
   logic [1:0] cur_size = 2'd0;

   logic [7:0] mem    [MSZ];
   logic [7:0] shadow [MSZ];

   always #2 clk = ~clk;

   blkop_engine #(.AW(AW), .CW(CW), .DW(DW)) u_blkop_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dir_down_set(dir_down_set), .dir_up_set(dir_up_set),
      .cfg_size(cfg_size), .cfg_op(cfg_op), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_count(cfg_count), .cfg_fill(cfg_fill),
      .busy(busy), .done(done), .dir_down(dir_down),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Memory model, R12: word holds bytes at the address with low 2 bits cleared
   always @(posedge clk) begin
      if (mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[{mem_addr[AW-1:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end
      for (int b = 0; b < 4; b++)
         mem_rdata[8*b +: 8] <= mem[{mem_addr[AW-1:2], 2'(b)}];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int nbytes_of(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   // Write monitor, R11 lane enables and R5 write count
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         logic [3:0] exp_be;
         int nb;
         nb = nbytes_of(cur_size);
         exp_be = 4'(((1 << nb) - 1) << mem_addr[1:0]);
         wcount++;
         chk(mem_be == exp_be, "R11", "byte enables", mem_be, exp_be);
      end
   end

   task automatic model(input logic [1:0] sz, input bit fill_op, input bit dn,
                        input int s, input int d, input int n, input logic [31:0] fv);
      int nb;
      logic [7:0] tmp [4];
      nb = nbytes_of(sz);
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < nb; k++)
            tmp[k] = fill_op ? fv[8*k +: 8] : shadow[(s + k) & (MSZ - 1)];
         for (int k = 0; k < nb; k++)
            shadow[(d + k) & (MSZ - 1)] = tmp[k];
         s = dn ? s - nb : s + nb;
         d = dn ? d - nb : d + nb;
      end
   endtask

   task automatic set_dir(input int mode);
      // mode 0 none, 1 down, 2 up, 3 both
      @(negedge clk);
      dir_down_set = (mode == 1) || (mode == 3);
      dir_up_set   = (mode == 2) || (mode == 3);
      @(negedge clk);
      dir_down_set = 1'b0;
      dir_up_set   = 1'b0;
   endtask

   task automatic run(input logic [1:0] sz, input bit fill_op, input int dmode,
                      input int s, input int d, input int n, input logic [31:0] fv,
                      input bit intrude);
      int cyc, exp_cyc, diffs, guard;
      bit dn;
      if (dmode != 0) set_dir(dmode);
      dn = dir_down;
      if (dmode == 1) chk(dir_down == 1'b1, "R4", "flag after down pulse", dir_down, 1);
      if (dmode == 2 || dmode == 3) chk(dir_down == 1'b0, "R4", "flag after up pulse", dir_down, 0);
      model(sz, fill_op, dn, s, d, n, fv);
      @(negedge clk);
      cur_size  = sz;
      cfg_size  = sz;
      cfg_op    = fill_op;
      cfg_src   = AW'(s);
      cfg_dst   = AW'(d);
      cfg_count = CW'(n);
      cfg_fill  = fv;
      wcount    = 0;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         chk(done && !busy, "R7", "zero count done next cycle", {done, busy}, 2);
         repeat (3) @(negedge clk);
         chk(wcount == 0, "R7", "zero count writes", wcount, 0);
      end else begin
         chk(!done, "R10", "done cleared by start", done, 0);
         cyc = 0;
         guard = 0;
         while (!done && guard < 1000) begin
            if (busy) cyc++;
            if (intrude && cyc == 2) begin
               cfg_op    = ~fill_op;
               cfg_count = CW'(3);
               cfg_size  = 2'(sz + 1);
               cfg_fill  = ~fv;
               start     = 1'b1;
            end else begin
               start = 1'b0;
            end
            @(negedge clk);
            guard++;
         end
         start = 1'b0;
         exp_cyc = fill_op ? n : 2 * n;
         chk(cyc == exp_cyc, "R8", "busy cycles", cyc, exp_cyc);
         chk(wcount == n, "R5", "element writes", wcount, n);
         if (intrude) chk(wcount == n && !busy, "R9", "start while busy ignored", wcount, n);
         repeat (3) @(negedge clk);
         chk(done == 1'b1, "R10", "done stays set", done, 1);
      end
      diffs = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== shadow[i]) diffs++;
      if (fill_op) chk(diffs == 0, "R2", "fill memory image mismatches", diffs, 0);
      else         chk(diffs == 0, "R1", "copy memory image mismatches", diffs, 0);
      chk(diffs == 0, "R6", "stepping/direction memory image", diffs, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int s, d, n, nb;
      logic [1:0] sz;
      void'($urandom(32'd4711));
      for (int i = 0; i < MSZ; i++) begin
         mem[i]    = 8'($urandom);
         shadow[i] = mem[i];
      end
      repeat (4) @(negedge clk);
      chk(!busy && !done && !mem_we && !mem_re, "R10", "reset outputs",
          {busy, done, mem_we, mem_re}, 0);
      chk(dir_down == 1'b0, "R4", "reset direction forward", dir_down, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 fill bytes, forward by reset default (R4)
      run(2'd0, 1'b1, 0, 100, 301, 5, 32'hA5C3_1E77, 1'b0);
      // R1 R3 copy 4-byte elements backward
      run(2'd2, 1'b0, 1, 500, 700, 7, 32'h0, 1'b0);
      // R7 zero count
      run(2'd1, 1'b0, 0, 40, 80, 0, 32'h0, 1'b0);
      // R9 start while busy, 2-byte copy forward
      run(2'd1, 1'b0, 2, 200, 402, 9, 32'h0, 1'b1);
      // R5 single element fill, code 3 as 4 bytes (R3)
      run(2'd3, 1'b1, 1, 820, 640, 1, 32'h1234_5678, 1'b0);
      // R1 overlapping forward byte copy
      run(2'd0, 1'b0, 2, 600, 601, 12, 32'h0, 1'b0);
      // R4 both pulses together: up wins, fill 2-byte
      run(2'd1, 1'b1, 3, 0, 900, 6, 32'hBEEF_CAFE, 1'b0);

      for (int r = 0; r < 30; r++) begin
         sz = 2'($urandom % 3);
         nb = nbytes_of(sz);
         n  = 1 + int'($urandom % 40);
         s  = (160 + int'($urandom % 700)) & ~(nb - 1);
         d  = (160 + int'($urandom % 700)) & ~(nb - 1);
         run(sz, 1'($urandom % 2), 1 + int'($urandom % 2), s, d, n, $urandom,
             1'($urandom % 4 == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule